// File: doc/BRIEF.md
# Dual Programmable Countdown Timers

This block holds two independent down-counting timers for a small microcontroller. Each timer raises a one-cycle interrupt request when it underflows. The first timer is a one-shot counter. Its tick is the system clock divided by a fine or a coarse ratio, and a control bit picks the ratio. Once it underflows it holds zero until software starts it again. The second timer reloads itself from its preload register every time it underflows. Its tick is either a divided internal clock or a rising edge on an external event pin.

Software writes the block through a small register port with four addresses. Address 0 is the first timer's preload and address 1 is its control. Address 2 is the second timer's preload and address 3 is its control. Every control word uses the same three bits: bit 0 is run, bit 1 is the source select, and bit 2 is load. For the first timer the source select means coarse, and load means start. For the second timer the source select means external. Both current counts can be read at any time from dedicated outputs.

Top module: `dual_countdown_timers`

## Requirements
- R1: After reset both counts are 0, both interrupt requests are low, and both timers are stopped.
- R2: A control write to address 1 with bit 2 set copies the timer-0 preload into the timer-0 count and clears its prescaler. With bit 1 clear and bit 0 set, the count then drops by one every FINE_DIV cycles, the first drop coming FINE_DIV cycles after the write.
- R3: With timer-0 control bit 1 set, timer 0 drops by one every COARSE_DIV cycles.
- R4: A tick that arrives while a count is 0 is an underflow, and it pulses that timer's interrupt request for exactly one cycle. After an underflow, timer 0 holds 0 and raises no further request until the next start write.
- R5: A timer-0 control write that changes bit 1 clears the prescaler, so the first drop after the change comes a full new period after the write.
- R6: On an underflow, timer 1 reloads its count from its preload register in the same cycle that irq1 rises. It underflows once every preload+1 ticks.
- R7: With timer-1 control bit 1 clear and bit 0 set, timer 1 ticks once every T1_DIV cycles. A control write with bit 2 set loads the preload into the count and clears the timer-1 prescaler.
- R8: With timer-1 control bit 1 set, timer 1 drops by one for each rising edge of ext_evt. The drop shows on t1_count three clock edges after the edge. A held high level and the internal divider have no effect.
- R9: While a timer's run bit (control bit 0) is clear, its count holds its value. Setting the bit again resumes counting from that value.
- R10: A write to the timer-1 preload (address 2) leaves the running count untouched. The new value is loaded at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0..3) |
| wr_data | input | CNT_W | Write data |
| ext_evt | input | 1 | External event input for timer 1 |
| t0_count | output | CNT_W | Current timer-0 count |
| t1_count | output | CNT_W | Current timer-1 count |
| irq0 | output | 1 | Timer-0 underflow request pulse |
| irq1 | output | 1 | Timer-1 underflow request pulse |

## Verification
The bench builds the block with COARSE_DIV reduced to 16 and T1_DIV set to 8, and keeps FINE_DIV at 4. With these values the coarse path reaches underflow within a few dozen cycles. Because the three divisors differ, a tick taken from the wrong prescaler or the wrong ratio changes the cycle on which a count drops. The check that follows a selection change mid-period, together with the exact-cycle interrupt checks, exposes a prescaler that is not cleared and an off-by-one in the underflow rule.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    ADDR_T0_PRE = 2'd0,
    ADDR_T0_CTL = 2'd1,
    ADDR_T1_PRE = 2'd2,
    ADDR_T1_CTL = 2'd3
  } dct_addr_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_SEL  = 1;
  localparam int CTL_LOAD = 2;

  // terminal prescaler value for the selected ratio
  function automatic int unsigned psc_last(input logic sel, input int unsigned div_a,
                                           input int unsigned div_b);
    return sel ? (div_b - 1) : (div_a - 1);
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic sel,
  output logic tick
);
  import dct_pkg::*;
  localparam int unsigned MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = CW'(psc_last(sel, DIV_A, DIV_B));
  assign tick = en && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dct_edge_sync.sv
module dct_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q && !s3_q;
endmodule

// File: rtl/dct_down_counter.sv
module dct_down_counter #(
  parameter int unsigned W           = 8,
  parameter bit          AUTO_RELOAD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] preload,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         irq
);
  function automatic logic [W-1:0] dec1(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  function automatic logic at_floor(input logic [W-1:0] v);
    return v == '0;
  endfunction

  logic         halted;
  logic         step;
  logic         uf_evt;
  logic [W-1:0] count_q;

  assign step   = run && tick && !halted && !load;
  assign uf_evt = step && at_floor(count_q);

  generate
    if (AUTO_RELOAD) begin : g_reload
      assign halted = 1'b0;
    end else begin : g_oneshot
      logic halt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      halt_q <= 1'b1;
        else if (load)   halt_q <= 1'b0;
        else if (uf_evt) halt_q <= 1'b1;
      end
      assign halted = halt_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= uf_evt;
      if (load)
        count_q <= preload;
      else if (uf_evt)
        count_q <= AUTO_RELOAD ? preload : count_q;
      else if (step)
        count_q <= dec1(count_q);
    end
  end

  assign count = count_q;
endmodule

// File: rtl/dual_countdown_timers.sv
module dual_countdown_timers #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned FINE_DIV   = 4,
  parameter int unsigned COARSE_DIV = 1024,
  parameter int unsigned T1_DIV     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_evt,
  output logic [CNT_W-1:0] t0_count,
  output logic [CNT_W-1:0] t1_count,
  output logic             irq0,
  output logic             irq1
);
  import dct_pkg::*;

  logic [CNT_W-1:0] t0_pre, t1_pre;
  logic             t0_run, t0_coarse, t1_run, t1_ext;
  logic             wr_t0_ctl, wr_t1_ctl;
  logic             t0_load, t1_load, t0_psc_clr;
  logic             t0_tick, t1_int_tick, t1_rise, t1_tick;

  assign wr_t0_ctl  = wr_en && (wr_addr == ADDR_T0_CTL);
  assign wr_t1_ctl  = wr_en && (wr_addr == ADDR_T1_CTL);
  assign t0_load    = wr_t0_ctl && wr_data[CTL_LOAD];
  assign t1_load    = wr_t1_ctl && wr_data[CTL_LOAD];
  assign t0_psc_clr = t0_load || (wr_t0_ctl && (wr_data[CTL_SEL] != t0_coarse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_pre    <= '0;
      t1_pre    <= '0;
      t0_run    <= 1'b0;
      t0_coarse <= 1'b0;
      t1_run    <= 1'b0;
      t1_ext    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_T0_PRE: t0_pre <= wr_data;
        ADDR_T0_CTL: begin
          t0_run    <= wr_data[CTL_RUN];
          t0_coarse <= wr_data[CTL_SEL];
        end
        ADDR_T1_PRE: t1_pre <= wr_data;
        default: begin
          t1_run <= wr_data[CTL_RUN];
          t1_ext <= wr_data[CTL_SEL];
        end
      endcase
    end
  end

  dct_prescaler #(.DIV_A(FINE_DIV), .DIV_B(COARSE_DIV)) u_psc0 (
    .clk(clk), .rst_n(rst_n), .en(t0_run), .clr(t0_psc_clr),
    .sel(t0_coarse), .tick(t0_tick));

  dct_prescaler #(.DIV_A(T1_DIV), .DIV_B(T1_DIV)) u_psc1 (
    .clk(clk), .rst_n(rst_n), .en(t1_run && !t1_ext), .clr(t1_load),
    .sel(1'b0), .tick(t1_int_tick));

  dct_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_evt), .rise(t1_rise));

  assign t1_tick = t1_ext ? t1_rise : t1_int_tick;

  dct_down_counter #(.W(CNT_W), .AUTO_RELOAD(1'b0)) u_cnt0 (
    .clk(clk), .rst_n(rst_n), .load(t0_load), .preload(t0_pre),
    .run(t0_run), .tick(t0_tick), .count(t0_count), .irq(irq0));

  dct_down_counter #(.W(CNT_W), .AUTO_RELOAD(1'b1)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .load(t1_load), .preload(t1_pre),
    .run(t1_run), .tick(t1_tick), .count(t1_count), .irq(irq1));
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] t0_count,
  input logic [CNT_W-1:0] t1_count,
  input logic             irq0,
  input logic             irq1,
  input logic             t0_load,
  input logic             t1_load,
  input logic             t0_run,
  input logic             t1_run,
  input logic             t0_tick,
  input logic             t1_rise,
  input logic             t1_ext,
  input logic [CNT_W-1:0] t1_pre
);
  // R2
  t0_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_run && t0_tick && t0_count != '0 && !t0_load)
      |=> t0_count == $past(t0_count) - {{(CNT_W-1){1'b0}}, 1'b1});

  // R4
  t0_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);

  // R4
  t0_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_count == '0 && !t0_load) |=> t0_count == '0);

  // R6
  t1_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> t1_count == $past(t1_pre));

  // R8
  t1_ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_run && t1_ext && !t1_rise && !t1_load) |=> $stable(t1_count));

  // R9
  t0_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0_run && !t0_load) |=> $stable(t0_count));

  // R9
  t1_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t1_run && !t1_load) |=> $stable(t1_count));
endmodule

bind dual_countdown_timers dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .t0_count(t0_count), .t1_count(t1_count),
  .irq0(irq0), .irq1(irq1), .t0_load(t0_load), .t1_load(t1_load),
  .t0_run(t0_run), .t1_run(t1_run), .t0_tick(t0_tick), .t1_rise(t1_rise),
  .t1_ext(t1_ext), .t1_pre(t1_pre));

// File: tb/dual_countdown_timers_tb.sv
`timescale 1ns/1ps
module dual_countdown_timers_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         ext_evt;
  logic [W-1:0] t0_count, t1_count;
  logic         irq0, irq1;

  always #4 clk = ~clk;

  dual_countdown_timers #(.CNT_W(W), .FINE_DIV(4), .COARSE_DIV(16), .T1_DIV(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_evt(ext_evt), .t0_count(t0_count), .t1_count(t1_count),
    .irq0(irq0), .irq1(irq1));

  // which output an expected item refers to
  typedef enum int {S_T0 = 0, S_T1 = 1, S_IRQ0 = 2, S_IRQ1 = 3} sig_e;
  typedef struct {
    string req;
    sig_e  sig;
    int    exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic expect_out(input string req, input sig_e s, input int v);
    item_t it;
    it.req = req; it.sig = s; it.exp = v;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compare queued expectations against the outputs between edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sig)
          S_T0:    act = int'(t0_count);
          S_T1:    act = int'(t1_count);
          S_IRQ0:  act = int'(irq0);
          default: act = int'(irq1);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s %s actual=%0d expected=%0d", it.req, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_evt = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state, nothing counting
    expect_out("R1", S_T0, 0); expect_out("R1", S_T1, 0);
    expect_out("R1", S_IRQ0, 0); expect_out("R1", S_IRQ1, 0);
    step(10);
    expect_out("R1", S_T0, 0); expect_out("R1", S_IRQ1, 0);

    // R2 fine prescale, preload 3
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h05);
    expect_out("R2", S_T0, 3);
    step(3); expect_out("R2", S_T0, 3);
    step(1); expect_out("R2", S_T0, 2);
    step(11); expect_out("R4", S_T0, 0); expect_out("R4", S_IRQ0, 0);
    step(1); expect_out("R4", S_IRQ0, 1);
    step(1); expect_out("R4", S_IRQ0, 0);
    step(20); expect_out("R4", S_T0, 0); expect_out("R4", S_IRQ0, 0);

    // R3 coarse prescale, preload 2
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h07);
    expect_out("R3", S_T0, 2);
    step(15); expect_out("R3", S_T0, 2);
    step(1);  expect_out("R3", S_T0, 1);
    step(31); expect_out("R3", S_T0, 0); expect_out("R3", S_IRQ0, 0);
    step(1);  expect_out("R3", S_IRQ0, 1);
    step(1);  expect_out("R4", S_IRQ0, 0);
    step(30); expect_out("R4", S_T0, 0); expect_out("R4", S_IRQ0, 0);
    // R4 restart after halt
    wr(2'd1, 8'h05);
    expect_out("R4", S_T0, 2);
    step(4); expect_out("R2", S_T0, 1);

    // R5 selection change clears the prescaler mid-period
    wr(2'd0, 8'd10);
    wr(2'd1, 8'h05);
    step(10); expect_out("R5", S_T0, 8);
    wr(2'd1, 8'h03);
    expect_out("R5", S_T0, 8);
    step(15); expect_out("R5", S_T0, 8);
    step(1);  expect_out("R5", S_T0, 7);

    // R9 timer 0 freeze
    wr(2'd1, 8'h02);
    expect_out("R9", S_T0, 7);
    step(40); expect_out("R9", S_T0, 7); expect_out("R9", S_IRQ0, 0);

    // R7 / R6 timer 1 internal tick with auto reload
    wr(2'd2, 8'd2);
    wr(2'd3, 8'h05);
    expect_out("R7", S_T1, 2);
    step(7);  expect_out("R7", S_T1, 2);
    step(1);  expect_out("R7", S_T1, 1);
    step(15); expect_out("R6", S_T1, 0); expect_out("R6", S_IRQ1, 0);
    step(1);  expect_out("R6", S_T1, 2); expect_out("R6", S_IRQ1, 1);
    step(1);  expect_out("R6", S_IRQ1, 0);
    // R10 preload write while running
    wr(2'd2, 8'd5);
    expect_out("R10", S_T1, 2);
    step(21); expect_out("R10", S_T1, 0);
    step(1);  expect_out("R10", S_T1, 5); expect_out("R10", S_IRQ1, 1);
    // R9 timer 1 freeze and resume
    wr(2'd3, 8'h00);
    expect_out("R9", S_T1, 5);
    step(30); expect_out("R9", S_T1, 5);
    wr(2'd3, 8'h01);
    expect_out("R9", S_T1, 5);
    step(12); expect_out("R9", S_T1, 4);

    // R8 external event counting
    wr(2'd2, 8'd3);
    wr(2'd3, 8'h07);
    expect_out("R8", S_T1, 3);
    step(20); expect_out("R8", S_T1, 3);
    ext_evt = 1'b1;
    step(2); expect_out("R8", S_T1, 3);
    step(1); expect_out("R8", S_T1, 2);
    step(5); expect_out("R8", S_T1, 2);
    ext_evt = 1'b0; step(4);
    ext_evt = 1'b1; step(3); expect_out("R8", S_T1, 1);
    ext_evt = 1'b0; step(4);
    ext_evt = 1'b1; step(3); expect_out("R8", S_T1, 0);
    ext_evt = 1'b0; step(4);
    ext_evt = 1'b1;
    step(2); expect_out("R8", S_T1, 0); expect_out("R8", S_IRQ1, 0);
    step(1); expect_out("R6", S_T1, 3); expect_out("R6", S_IRQ1, 1);
    step(1); expect_out("R6", S_IRQ1, 0);
    ext_evt = 1'b0;

    step(3);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule